// File: doc/BRIEF.md
# SPI FIFO Interrupt Status Controller

This block produces the interrupt status word and the single interrupt line of a serial peripheral controller whose transmit and receive queues hold bytes. It watches the occupancy counts and full flags of both queues and three one-cycle event pulses: transmit underflow, receive overflow and mode fault. From these it forms a 7-bit status word. The three event bits are held until software clears them. The four queue-state bits are recomputed every cycle, with the two "room/data available" bits compared against programmable thresholds.

Software reaches the block over a small register bus with a 3-bit address, a write strobe, write data and combinational read data. The address map is: 0 status, 1 mask-set, 2 mask-clear, 3 mask (read only), 4 transmit threshold, 5 receive threshold. The mask changes only through the set and clear ports, never by a direct write. The interrupt line is high while any masked-in status bit is set.

The block has no sequencer. Its state is the three sticky flags, the mask and the two thresholds. Each sticky flag moves between two named states: CLEAR → SET on an event pulse, and SET → CLEAR on a write of 1 to its status bit. The event wins when both arrive in the same cycle.

Top module: `spi_irq_ctrl`

## Requirements
- R1: The status word (address 0) has bit 6 transmit underflow, bit 5 receive full, bit 4 receive data-available, bit 3 transmit full, bit 2 transmit room-available, bit 1 mode fault, bit 0 receive overflow. All data bits above bit 6 read as 0.
- R2: An event pulse sets its sticky bit (6, 1 or 0) at the next clock edge, and the bit stays set after the pulse ends.
- R3: Writing the status address clears exactly those sticky bits whose write-data bit is 1. Bits written with 0 keep their value.
- R4: When an event pulse and a write-1-to-clear hit the same sticky bit in the same cycle, the bit ends up set.
- R5: Status bit 4 is 1 exactly when the receive count is greater than or equal to the receive threshold.
- R6: Status bit 2 is 1 exactly when the transmit count is strictly less than the transmit threshold.
- R7: Status bits 5 and 3 follow the receive-full and transmit-full inputs in the same cycle, with no storage.
- R8: Writing address 1 sets the mask bits that are 1 in the data. Writing address 2 clears them. A write to address 3 has no effect. Addresses 1 and 2 read as 0, and address 3 reads the mask.
- R9: The interrupt output is 1 exactly when the bitwise AND of mask and status is non-zero.
- R10: After reset, both thresholds are 1, the mask is 0 and all sticky bits are 0.
- R11: Writing address 4 or 5 loads the low 6 data bits into the transmit or receive threshold, and the value reads back at the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| tx_count | input | 6 | Transmit queue occupancy, 0..32 |
| rx_count | input | 6 | Receive queue occupancy, 0..32 |
| tx_full | input | 1 | Transmit queue full |
| rx_full | input | 1 | Receive queue full |
| ev_tx_underflow | input | 1 | Transmit underflow event pulse |
| ev_rx_overflow | input | 1 | Receive overflow event pulse |
| ev_mode_fault | input | 1 | Mode fault event pulse |
| irq | output | 1 | Level interrupt |

## Verification
A sticky flag that drops or sets at the wrong time shows in the status readback on the first sample after the offending edge. When its mask bit is enabled, the same error appears on the interrupt line in that cycle. A wrong comparison in the threshold logic shows without any clock delay, because the level bits are combinational from the counts. The stimulus therefore places counts on both sides of each threshold, including equality and the zero-threshold case. A mask or threshold register that accepts the wrong write is caught by reading it back once the write cycle has completed.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
    localparam int STAT_W = 7;

    localparam int B_RX_OVF  = 0;
    localparam int B_MODE    = 1;
    localparam int B_TX_ROOM = 2;
    localparam int B_TX_FULL = 3;
    localparam int B_RX_DATA = 4;
    localparam int B_RX_FULL = 5;
    localparam int B_TX_UNF  = 6;

    localparam int N_STICKY = 3;

    typedef enum logic [2:0] {
        A_STATUS   = 3'd0,
        A_MASK_SET = 3'd1,
        A_MASK_CLR = 3'd2,
        A_MASK     = 3'd3,
        A_TX_THR   = 3'd4,
        A_RX_THR   = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/spi_irq_sticky.sv
module spi_irq_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    typedef enum logic {S_CLEAR = 1'b0, S_SET = 1'b1} flag_e;

    generate
        for (genvar i = 0; i < N; i++) begin : g_flag
            flag_e st, st_nx;

            always_comb begin
                st_nx = st;
                unique case (st)
                    S_CLEAR: if (ev[i]) st_nx = S_SET;
                    S_SET:   if (clr[i] && !ev[i]) st_nx = S_CLEAR;
                    default: st_nx = S_CLEAR;
                endcase
            end

            always_ff @(posedge clk) begin
                if (!rst_n) st <= S_CLEAR;
                else        st <= st_nx;
            end

            assign q[i] = (st == S_SET);

            assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
                ev[i] |=> q[i]);
            assert_hold_without_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (q[i] && !clr[i]) |=> q[i]);
            assert_set_beats_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (ev[i] && clr[i]) |=> q[i]);
            assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (!q[i] && !ev[i]) |=> !q[i]);
        end
    endgenerate
endmodule

// File: rtl/spi_irq_level.sv
module spi_irq_level #(
    parameter int CNT_W = 6
) (
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_thr,
    input  logic [CNT_W-1:0] rx_thr,
    output logic             tx_room,
    output logic             rx_data
);
    always_comb begin
        tx_room = (tx_count <  tx_thr);
        rx_data = (rx_count >= rx_thr);
    end
endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
    import spi_irq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [STAT_W-1:0] mask,
    output logic [CNT_W-1:0]  tx_thr,
    output logic [CNT_W-1:0]  rx_thr
);
    localparam logic [CNT_W-1:0] THR_RST = CNT_W'(1);

    logic [STAT_W-1:0] wbits;
    logic              wr_set, wr_clr, wr_tx, wr_rx;

    always_comb begin
        wbits  = wdata[STAT_W-1:0];
        wr_set = wr && (addr == A_MASK_SET);
        wr_clr = wr && (addr == A_MASK_CLR);
        wr_tx  = wr && (addr == A_TX_THR);
        wr_rx  = wr && (addr == A_RX_THR);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask   <= '0;
            tx_thr <= THR_RST;
            rx_thr <= THR_RST;
        end else begin
            if (wr_set)      mask <= mask | wbits;
            else if (wr_clr) mask <= mask & ~wbits;
            if (wr_tx) tx_thr <= wdata[CNT_W-1:0];
            if (wr_rx) rx_thr <= wdata[CNT_W-1:0];
        end
    end

    assert_mask_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((mask & $past(wbits)) == $past(wbits)));
    assert_mask_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((mask & $past(wbits)) == '0));
    assert_mask_still_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_set && !wr_clr) |=> $stable(mask));
    assert_thr_still_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_tx && !wr_rx) |=> ($stable(tx_thr) && $stable(rx_thr)));
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
    import spi_irq_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic              tx_full,
    input  logic              rx_full,
    input  logic              ev_tx_underflow,
    input  logic              ev_rx_overflow,
    input  logic              ev_mode_fault,
    output logic              irq
);
    logic [STAT_W-1:0]   mask, status;
    logic [CNT_W-1:0]    tx_thr, rx_thr;
    logic                tx_room, rx_data;
    logic [N_STICKY-1:0] st_ev, st_clr, st_q;
    logic                wr_status;

    always_comb begin
        wr_status = bus_wr && (bus_addr == A_STATUS);
        st_ev  = {ev_tx_underflow, ev_mode_fault, ev_rx_overflow};
        st_clr = wr_status ? {bus_wdata[B_TX_UNF], bus_wdata[B_MODE], bus_wdata[B_RX_OVF]}
                           : '0;
    end

    spi_irq_sticky #(.N(N_STICKY)) u_sticky (
        .clk(clk), .rst_n(rst_n), .ev(st_ev), .clr(st_clr), .q(st_q)
    );

    spi_irq_level #(.CNT_W(CNT_W)) u_level (
        .tx_count(tx_count), .rx_count(rx_count),
        .tx_thr(tx_thr), .rx_thr(rx_thr),
        .tx_room(tx_room), .rx_data(rx_data)
    );

    spi_irq_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .mask(mask), .tx_thr(tx_thr), .rx_thr(rx_thr)
    );

    always_comb begin
        status             = '0;
        status[B_RX_OVF]   = st_q[0];
        status[B_MODE]     = st_q[1];
        status[B_TX_UNF]   = st_q[2];
        status[B_TX_ROOM]  = tx_room;
        status[B_TX_FULL]  = tx_full;
        status[B_RX_DATA]  = rx_data;
        status[B_RX_FULL]  = rx_full;
    end

    assign irq = |(mask & status);

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_STATUS: bus_rdata = DATA_W'(status);
            A_MASK:   bus_rdata = DATA_W'(mask);
            A_TX_THR: bus_rdata = DATA_W'(tx_thr);
            A_RX_THR: bus_rdata = DATA_W'(rx_thr);
            default:  bus_rdata = '0;
        endcase
    end

    assert_underflow_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_underflow |=> status[B_TX_UNF]);
    assert_irq_needs_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);
endmodule

// File: tb/spi_irq_ctrl_test.sv
module spi_irq_ctrl_test;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [5:0] tx_count = '0, rx_count = '0;
    logic       tx_full = 1'b0, rx_full = 1'b0;
    logic       ev_unf = 1'b0, ev_ovf = 1'b0, ev_mf = 1'b0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    spi_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_count(tx_count), .rx_count(rx_count),
        .tx_full(tx_full), .rx_full(rx_full),
        .ev_tx_underflow(ev_unf), .ev_rx_overflow(ev_ovf), .ev_mode_fault(ev_mf),
        .irq(irq)
    );

    // txc, rxc, tx threshold, rx threshold, expected tx room (bit2), rx data (bit4)
    localparam logic [25:0] VEC [6] = '{
        {6'd0,  6'd0,  6'd1,  6'd1,  1'b1, 1'b0},
        {6'd1,  6'd1,  6'd1,  6'd1,  1'b0, 1'b1},
        {6'd5,  6'd4,  6'd6,  6'd5,  1'b1, 1'b0},
        {6'd6,  6'd5,  6'd6,  6'd5,  1'b0, 1'b1},
        {6'd31, 6'd32, 6'd32, 6'd32, 1'b1, 1'b1},
        {6'd0,  6'd0,  6'd0,  6'd0,  1'b0, 1'b1}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        rd(3'd0, r); check("R10 status after reset", r, 8'h04);
        rd(3'd3, r); check("R10 mask after reset", r, 8'h00);
        rd(3'd4, r); check("R10 tx threshold after reset", r, 8'h01);
        rd(3'd5, r); check("R10 rx threshold after reset", r, 8'h01);
        check("R10 irq after reset", {7'd0, irq}, 8'h00);

        // R5 R6 R11 threshold vector table
        for (int i = 0; i < 6; i++) begin
            wr(3'd4, {2'b00, VEC[i][13:8]});
            wr(3'd5, {2'b00, VEC[i][7:2]});
            tx_count = VEC[i][25:20];
            rx_count = VEC[i][19:14];
            rd(3'd4, r); check("R11 tx threshold readback", r, {2'b00, VEC[i][13:8]});
            rd(3'd5, r); check("R11 rx threshold readback", r, {2'b00, VEC[i][7:2]});
            rd(3'd0, r);
            check("R5 R6 level bits", r, {3'b000, VEC[i][0], 1'b0, VEC[i][1], 2'b00});
        end
        wr(3'd4, 8'd1); wr(3'd5, 8'd1);
        tx_count = 6'd4; rx_count = 6'd0;

        // R7 full flags
        tx_full = 1'b1; rx_full = 1'b1;
        rd(3'd0, r); check("R7 full flags", r, 8'h28);
        tx_full = 1'b0; rx_full = 1'b0;
        rd(3'd0, r); check("R7 full flags cleared", r, 8'h00);

        // R2 R1 sticky events and bit positions
        @(negedge clk); ev_ovf = 1'b1;
        @(negedge clk); ev_ovf = 1'b0;
        rd(3'd0, r); check("R2 overflow sticks at bit 0", r, 8'h01);
        @(negedge clk); ev_unf = 1'b1; ev_mf = 1'b1;
        @(negedge clk); ev_unf = 1'b0; ev_mf = 1'b0;
        repeat (2) @(negedge clk);
        rd(3'd0, r); check("R1 R2 underflow bit 6 mode bit 1", r, 8'h43);

        // R3 write-1-to-clear
        wr(3'd0, 8'h00);
        rd(3'd0, r); check("R3 zero write keeps bits", r, 8'h43);
        wr(3'd0, 8'h01);
        rd(3'd0, r); check("R3 clear bit 0 only", r, 8'h42);

        // R4 set beats clear
        @(negedge clk);
        bus_addr = 3'd0; bus_wdata = 8'h02; bus_wr = 1'b1; ev_mf = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; ev_mf = 1'b0;
        rd(3'd0, r); check("R4 set wins", r, 8'h42);

        // R8 mask set/clear/ignored write
        wr(3'd1, 8'h41);
        rd(3'd3, r); check("R8 mask set", r, 8'h41);
        rd(3'd1, r); check("R8 set port reads 0", r, 8'h00);
        rd(3'd2, r); check("R8 clear port reads 0", r, 8'h00);
        wr(3'd2, 8'h01);
        rd(3'd3, r); check("R8 mask clear", r, 8'h40);
        wr(3'd3, 8'hFF);
        rd(3'd3, r); check("R8 direct mask write ignored", r, 8'h40);

        // R9 interrupt line
        check("R9 irq from underflow", {7'd0, irq}, 8'h01);
        wr(3'd0, 8'h42);
        #1; check("R9 irq drops after clear", {7'd0, irq}, 8'h00);
        wr(3'd1, 8'h04);
        tx_count = 6'd0;
        #1; check("R9 irq from tx room level", {7'd0, irq}, 8'h01);
        tx_count = 6'd3;
        #1; check("R9 irq follows level", {7'd0, irq}, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule